// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address using a two-level table held in memory. A request gives the linear address, a write flag and a user-level flag. The block first reads an entry from a directory whose base comes from a base-address input. That entry points to a second-level table. The block then reads the table entry, which supplies the 4 KB page frame.

While it walks, the block keeps the status bits of the entries up to date. The accessed bit is set in both levels. The dirty bit is set in the leaf entry when the access is a write. An entry is written back only when one of these bits actually changes. A missing entry or a protection violation ends the walk with a fault, and the faulting linear address is kept in a register. When paging is off, the address passes through unchanged and memory is not touched.

The walker serves one request at a time. Table memory is reached through a simple one-word request/acknowledge port.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to word address `{dir_base[31:12], lin[31:22], 2'b00}`. The second read goes to `{dir_entry[31:12], lin[21:12], 2'b00}`. Each table therefore has 1024 four-byte entries.
- R2: A successful walk returns `xl_phys = {leaf_entry[31:12], lin[11:0]}`.
- R3: Bits 11:0 of `dir_base` have no effect on any memory address or on the result.
- R4: An entry with bit 0 (present) clear ends the walk with `xl_fault`. That entry is not written, and no later level is read.
- R5: On a fault, `fault_lin` takes the request's linear address. It keeps that value through later successful walks until the next fault.
- R6: Bit 2 of an entry is the user-allowed flag and bit 1 is the writable flag. A user-level access faults when either level has bit 2 clear. A user-level write also faults when either level has bit 1 clear. Supervisor accesses ignore both bits.
- R7: After a walk that passes a level, that level's entry has bit 5 (accessed) set. The leaf entry has bit 6 (dirty) set after a write. Bit 6 of the directory entry is left as it was.
- R8: With `paging_en` low, `xl_done` rises one cycle after acceptance with `xl_phys` equal to the linear address, and no memory request is made.
- R9: An entry is written back only if bit 5 or bit 6 changes. A walk over entries that already carry the needed bits makes no writes.
- R10: Once `mem_req` is raised, it stays high with its address, write flag and write data unchanged until `mem_ack` is sampled high.
- R11: Each accepted request yields exactly one single-cycle pulse, on `xl_done` or on `xl_fault`, and never both at once. A request is accepted only while no walk is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_valid | input | 1 | Translation request; accepted when the walker is idle |
| xl_lin | input | 32 | Linear address of the request |
| xl_write | input | 1 | Request is a write |
| xl_user | input | 1 | Request is made at user level |
| paging_en | input | 1 | Paging on; when low, the address passes through |
| dir_base | input | 32 | Physical base of the directory (bits 11:0 ignored) |
| mem_req | output | 1 | Table memory request |
| mem_we | output | 1 | Request is an entry write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory accepts the request this cycle (read data valid) |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |
| xl_done | output | 1 | One-cycle pulse: translation finished |
| xl_fault | output | 1 | One-cycle pulse: walk ended in a page fault |
| xl_phys | output | 32 | Physical address of the last successful translation |
| fault_lin | output | 32 | Linear address of the most recent fault |

## Verification
The assertions assume three things about the inputs. `xl_valid` is raised only between walks and never in the cycle right after a done or fault pulse. `mem_ack` is driven only while `mem_req` is high. `mem_rdata` is valid in the cycle of the acknowledge. The bench's memory model meets these conditions. It issues a new request only after it has seen the previous pulse. It computes the acknowledge from the current `mem_req` with a random stall, and it returns the word at the requested address. It keeps directory pointers inside the modelled 16 KB so that every entry read or written is a real stored word.

// File: rtl/pw_pkg.sv
package pw_pkg;
  parameter int PW_AW    = 32;
  parameter int PW_OFS_W = 12;
  parameter int PW_IDX_W = 10;
  localparam int PW_FRM_W = PW_AW - PW_OFS_W;

  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  typedef logic [PW_AW-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL
  } walk_st_e;

  function automatic word_t dir_entry_addr(word_t base, word_t lin);
    return {base[PW_AW-1:PW_OFS_W], lin[PW_AW-1 -: PW_IDX_W], 2'b00};
  endfunction

  function automatic word_t tbl_entry_addr(word_t ent, word_t lin);
    return {ent[PW_AW-1:PW_OFS_W], lin[PW_OFS_W+PW_IDX_W-1:PW_OFS_W], 2'b00};
  endfunction

  function automatic word_t phys_of(word_t ent, word_t lin);
    return {ent[PW_AW-1:PW_OFS_W], lin[PW_OFS_W-1:0]};
  endfunction

  function automatic logic entry_denied(word_t ent, logic usr, logic wr);
    return !ent[BIT_P] || (usr && !ent[BIT_US]) || (usr && wr && !ent[BIT_RW]);
  endfunction

  function automatic word_t entry_marked(word_t ent, logic leaf, logic wr);
    word_t r;
    r = ent;
    r[BIT_A] = 1'b1;
    if (leaf && wr) r[BIT_D] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
(
  input  logic [PW_AW-1:0] ent,
  input  logic             usr,
  input  logic             wr,
  input  logic             leaf,
  output logic             denied,
  output logic [PW_AW-1:0] upd,
  output logic             changed
);
  always_comb begin
    denied  = entry_denied(ent, usr, wr);
    upd     = entry_marked(ent, leaf, wr);
    changed = (upd != ent);
  end
endmodule

// File: rtl/pw_addr_sel.sv
module pw_addr_sel
  import pw_pkg::*;
(
  input  logic             tbl_phase,
  input  logic [PW_AW-1:0] base,
  input  logic [PW_AW-1:0] pde,
  input  logic [PW_AW-1:0] lin,
  output logic [PW_AW-1:0] addr
);
  always_comb begin
    if (tbl_phase) addr = tbl_entry_addr(pde, lin);
    else           addr = dir_entry_addr(base, lin);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xl_valid,
  input  logic [PW_AW-1:0] xl_lin,
  input  logic             xl_write,
  input  logic             xl_user,
  input  logic             paging_en,
  input  logic [PW_AW-1:0] dir_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PW_AW-1:0] mem_addr,
  output logic [PW_AW-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PW_AW-1:0] mem_rdata,
  output logic             xl_done,
  output logic             xl_fault,
  output logic [PW_AW-1:0] xl_phys,
  output logic [PW_AW-1:0] fault_lin
);
  walk_st_e         state;
  logic [PW_AW-1:0] lin_q, base_q, pde_q, pte_q;
  logic             wr_q, usr_q;

  // named internal events
  logic             st_idle, dir_phase, tbl_phase, rd_phase, leaf_phase;
  logic             ent_denied, ent_changed;
  logic [PW_AW-1:0] ent_in, ent_upd;

  assign st_idle    = (state == ST_IDLE);
  assign dir_phase  = (state == ST_RD_DIR) || (state == ST_WB_DIR);
  assign tbl_phase  = (state == ST_RD_TBL) || (state == ST_WB_TBL);
  assign rd_phase   = (state == ST_RD_DIR) || (state == ST_RD_TBL);
  assign leaf_phase = (state == ST_RD_TBL);
  assign ent_in     = rd_phase ? mem_rdata : '0;

  pw_entry_check i_check (
    .ent     (ent_in),
    .usr     (usr_q),
    .wr      (wr_q),
    .leaf    (leaf_phase),
    .denied  (ent_denied),
    .upd     (ent_upd),
    .changed (ent_changed)
  );

  pw_addr_sel i_addr (
    .tbl_phase (tbl_phase),
    .base      (base_q),
    .pde       (pde_q),
    .lin       (lin_q),
    .addr      (mem_addr)
  );

  assign mem_req   = !st_idle;
  assign mem_we    = (state == ST_WB_DIR) || (state == ST_WB_TBL);
  assign mem_wdata = (state == ST_WB_DIR) ? pde_q : pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lin_q     <= '0;
      base_q    <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      xl_done   <= 1'b0;
      xl_fault  <= 1'b0;
      xl_phys   <= '0;
      fault_lin <= '0;
    end else begin
      xl_done  <= 1'b0;
      xl_fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (xl_valid) begin
            lin_q  <= xl_lin;
            base_q <= dir_base;
            wr_q   <= xl_write;
            usr_q  <= xl_user;
            if (!paging_en) begin
              xl_phys <= xl_lin;
              xl_done <= 1'b1;
            end else begin
              state <= ST_RD_DIR;
            end
          end
        end
        ST_RD_DIR: begin
          if (mem_ack) begin
            if (ent_denied) begin
              xl_fault  <= 1'b1;
              fault_lin <= lin_q;
              state     <= ST_IDLE;
            end else begin
              pde_q <= ent_upd;
              state <= ent_changed ? ST_WB_DIR : ST_RD_TBL;
            end
          end
        end
        ST_WB_DIR: begin
          if (mem_ack) state <= ST_RD_TBL;
        end
        ST_RD_TBL: begin
          if (mem_ack) begin
            if (ent_denied) begin
              xl_fault  <= 1'b1;
              fault_lin <= lin_q;
              state     <= ST_IDLE;
            end else if (ent_changed) begin
              pte_q <= ent_upd;
              state <= ST_WB_TBL;
            end else begin
              pte_q   <= ent_upd;
              xl_phys <= phys_of(ent_upd, lin_q);
              xl_done <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WB_TBL: begin
          if (mem_ack) begin
            xl_phys <= phys_of(pte_q, lin_q);
            xl_done <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_walk_checker.sv
module pw_walk_checker
  import pw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xl_valid,
  input logic [PW_AW-1:0] xl_lin,
  input logic             paging_en,
  input logic             mem_req,
  input logic             mem_we,
  input logic [PW_AW-1:0] mem_addr,
  input logic [PW_AW-1:0] mem_wdata,
  input logic             mem_ack,
  input logic             xl_done,
  input logic             xl_fault,
  input logic [PW_AW-1:0] xl_phys,
  input logic [PW_AW-1:0] fault_lin,
  input logic             st_idle,
  input logic             dir_phase
);
  logic [PW_AW-1:0] lin_c;
  always_ff @(posedge clk) begin
    if (!rst_n)                   lin_c <= '0;
    else if (st_idle && xl_valid) lin_c <= xl_lin;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_done && xl_fault)); // R11
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done || xl_fault) |=> !xl_done && !xl_fault); // R11
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && xl_valid && !paging_en |=> xl_done && xl_phys == $past(xl_lin)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !mem_req); // R8
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> fault_lin == lin_c); // R5
  AST_DIR_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && dir_phase |-> mem_addr[PW_OFS_W-1:2] == lin_c[PW_AW-1 -: PW_IDX_W] && mem_addr[1:0] == 2'b00); // R1
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BIT_A]); // R7
endmodule

bind pt_walker pw_walk_checker i_walk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xl_valid  (xl_valid),
  .xl_lin    (xl_lin),
  .paging_en (paging_en),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .xl_done   (xl_done),
  .xl_fault  (xl_fault),
  .xl_phys   (xl_phys),
  .fault_lin (fault_lin),
  .st_idle   (st_idle),
  .dir_phase (dir_phase)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_valid = 1'b0, xl_write = 1'b0, xl_user = 1'b0, paging_en = 1'b0;
  logic [31:0] xl_lin = '0, dir_base = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        xl_done, xl_fault;
  logic [31:0] xl_phys, fault_lin;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_lin(xl_lin),
    .xl_write(xl_write), .xl_user(xl_user), .paging_en(paging_en),
    .dir_base(dir_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .xl_done(xl_done), .xl_fault(xl_fault),
    .xl_phys(xl_phys), .fault_lin(fault_lin)
  );

  int n_cmp = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, hold_err = 0;
  logic [31:0] mem [4096];
  logic [31:0] ref_mem [4096];
  logic [31:0] last_fault = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: ack and read data set at the falling edge
  always @(negedge clk) begin
    mem_ack   = mem_req && (($urandom % 4) != 0);
    mem_rdata = mem[mem_addr[13:2]];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (pend && (!mem_req || mem_addr != pend_addr)) hold_err++;
      pend      = mem_req && !mem_ack;
      pend_addr = mem_addr;
      if (mem_req && mem_ack) begin
        if (mem_we) begin mem[mem_addr[13:2]] = mem_wdata; wr_cnt++; end
        else rd_cnt++;
      end
    end
  end

  task automatic fill_tables();
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] e;
      e = $urandom;
      e[31:12] = 20'(1 + ($urandom % 3));
      e[0] = ($urandom % 8) != 0;
      if ($urandom % 2 == 1) begin e[1] = 1'b1; e[2] = 1'b1; end
      mem[i] = e;
    end
    for (int i = 1024; i < 4096; i++) begin
      logic [31:0] e;
      e = $urandom;
      e[0] = ($urandom % 8) != 0;
      if ($urandom % 2 == 1) begin e[1] = 1'b1; e[2] = 1'b1; end
      mem[i] = e;
    end
    for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
  endtask

  task automatic put(input int idx, input logic [31:0] v);
    mem[idx] = v;
    ref_mem[idx] = v;
  endtask

  function automatic bit may_use(input logic [31:0] e, input bit wr, input bit usr);
    if (e[0] == 1'b0) return 1'b0;
    if (usr) begin
      if (e[2] == 1'b0) return 1'b0;
      if (wr && e[1] == 1'b0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic xlate(input logic [31:0] lin, input bit wr, input bit usr,
                       input bit pg, input string tag);
    bit          ef;
    logic [31:0] ep, pde, pte;
    int          ew, di, ti, w0, r0, cyc;
    ef = 0; ep = lin; ew = 0; di = 0; ti = 0;
    if (pg) begin
      di  = {dir_base[13:12], lin[31:22]};
      pde = ref_mem[di];
      if (!may_use(pde, wr, usr)) ef = 1;
      else begin
        if (!pde[5]) begin pde[5] = 1'b1; ref_mem[di] = pde; ew++; end
        ti  = {pde[13:12], lin[21:12]};
        pte = ref_mem[ti];
        if (!may_use(pte, wr, usr)) ef = 1;
        else begin
          if (!pte[5] || (wr && !pte[6])) begin
            pte[5] = 1'b1;
            if (wr) pte[6] = 1'b1;
            ref_mem[ti] = pte;
            ew++;
          end
          ep = {pte[31:12], lin[11:0]};
        end
      end
    end
    w0 = wr_cnt; r0 = rd_cnt; cyc = 0;
    @(negedge clk);
    xl_valid = 1'b1; xl_lin = lin; xl_write = wr; xl_user = usr; paging_en = pg;
    while (1) begin
      @(negedge clk);
      xl_valid = 1'b0;
      cyc++;
      if (xl_done || xl_fault || cyc > 400) break;
    end
    if (cyc > 400) begin
      chk(0, "R11", {tag, " walk timeout"}, 32'(cyc), 0);
      return;
    end
    chk(xl_fault == ef && xl_done == !ef, ef ? "R4/R6" : "R6", {tag, " outcome fault"},
        32'(xl_fault), 32'(ef));
    if (ef) begin
      last_fault = lin;
      chk(fault_lin == lin, "R5", {tag, " fault address"}, fault_lin, lin);
    end else begin
      chk(xl_phys == ep, "R1/R2", {tag, " physical address"}, xl_phys, ep);
      chk(fault_lin == last_fault, "R5", {tag, " fault address held"}, fault_lin, last_fault);
    end
    chk(wr_cnt - w0 == ew, "R9", {tag, " write-back count"}, 32'(wr_cnt - w0), 32'(ew));
    if (pg) begin
      chk(mem[di] == ref_mem[di], "R7", {tag, " directory entry"}, mem[di], ref_mem[di]);
      chk(mem[ti] == ref_mem[ti], "R7", {tag, " table entry"}, mem[ti], ref_mem[ti]);
    end else begin
      chk(rd_cnt == r0 && cyc == 1, "R8", {tag, " bypass reads/latency"}, 32'(rd_cnt - r0), 0);
    end
    @(negedge clk);
    chk(!xl_done && !xl_fault, "R11", {tag, " single pulse"}, 32'({xl_done, xl_fault}), 0);
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog expired: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fill_tables();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!xl_done && !xl_fault && !mem_req && fault_lin == 0 && xl_phys == 0,
        "R11", "reset state", {xl_done, xl_fault, mem_req}, 0);

    dir_base = 32'h0000_0ABC;  // R3: low bits must be ignored
    xlate(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, "R8 bypass");
    // directory idx 5 -> table frame 2, leaf idx 7 -> frame 12345
    put(5, 32'h0000_2047);              // dirty bit preset in directory (R7)
    put(32'h807, 32'h1234_5007);
    xlate(32'h0140_7ABC, 1'b0, 1'b1, 1'b1, "R7 first read");
    xlate(32'h0140_7ABC, 1'b1, 1'b1, 1'b1, "R7 dirty on write");
    xlate(32'h0140_7123, 1'b1, 1'b1, 1'b1, "R9 no change");
    put(6, 32'h0000_2006);
    xlate(32'h0180_0000, 1'b0, 1'b0, 1'b1, "R4 dir absent");
    put(32'h808, 32'h5555_5006);
    xlate(32'h0140_8010, 1'b0, 1'b0, 1'b1, "R4 leaf absent");
    put(32'h809, 32'h7777_7003);
    xlate(32'h0140_9020, 1'b0, 1'b1, 1'b1, "R6 user on supervisor page");
    xlate(32'h0140_9020, 1'b0, 1'b0, 1'b1, "R6 supervisor ok");
    put(32'h80A, 32'h8888_8005);
    xlate(32'h0140_A030, 1'b1, 1'b1, 1'b1, "R6 user write read-only");
    xlate(32'h0140_A030, 1'b1, 1'b0, 1'b1, "R6 supervisor write read-only");
    xlate(32'h0140_A040, 1'b0, 1'b1, 1'b1, "R6 user read read-only");
    dir_base = 32'h0000_0FFF;
    xlate(32'h0140_7ABC, 1'b0, 1'b0, 1'b1, "R3 base low bits");

    for (int k = 0; k < 400; k++) begin
      dir_base = {20'h0, 12'($urandom)};
      xlate($urandom, 1'($urandom), 1'($urandom), ($urandom % 8) != 0, "random");
    end

    n_cmp++;
    if (hold_err != 0) begin
      n_bad++;
      $display("FAIL R10 request dropped before ack: actual %0d expected 0", hold_err);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule